// File: doc/BRIEF.md
# Vector Narrowing Right-Shift Unit

This block carries out one vector operation: every wide lane of a 128-bit source is shifted right logically by an immediate amount, and only the lower half of each shifted lane is kept. The lanes produced this way are packed into a 64-bit result. A 7-bit immediate, given as a 4-bit upper field and a 3-bit lower field, encodes both the lane width and the shift distance. A half-select input decides where the packed result goes in the 128-bit destination. With half-select at 0 the result fills the low half and the high half is forced to zero. With half-select at 1 the result fills the high half and the low half keeps the incoming destination value.

A request is taken on any cycle with `req_valid` high, and the updated destination shows up on the following cycle together with `rsp_valid`. Two kinds of encoding never write. If the upper immediate field is zero, the encoding belongs to some other operation class; `rsp_other` is raised and no write happens. If the top bit of the upper field is set, `rsp_undef` is raised and no write happens. For debug, the decoded lane-size code and the shift amount are driven out on the same registered cycle.

Top module: `vnarrow_shr`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_write`, `rsp_undef` and `rsp_other` are all 0.
- R2: Each request sampled with `req_valid`=1 produces `rsp_valid`=1 on the very next clock edge, and `rsp_valid` is 0 one edge after a cycle with `req_valid`=0.
- R3: Upper field `imm_hi`=4'b0000 returns `rsp_other`=1, `rsp_undef`=0, `rsp_write`=0, and `rsp_dest` equal to the incoming `dst_in`.
- R4: `imm_hi[3]`=1 returns `rsp_undef`=1, `rsp_other`=0, `rsp_write`=0, and `rsp_dest` equal to `dst_in`.
- R5: In a legal encoding, the most significant set bit of `imm_hi[2:0]` picks the narrow lane width: bit 0 gives 8 bits (code 0), bit 1 gives 16 bits (code 1), bit 2 gives 32 bits (code 2). The code is driven on `dbg_size`.
- R6: The shift equals twice the narrow width minus the unsigned value of {imm_hi,imm_lo}. It falls in 1..width and is driven on `dbg_shift`.
- R7: Narrow lane e (e from 0 to 64/width-1) equals bits [width-1:0] of source lane e of width 2*width, taken from `src` bits starting at e*2*width, shifted right logically with truncation. Lane e sits at bits starting at e*width of the 64-bit result.
- R8: With `half_sel`=0 on a legal encoding, `rsp_dest[63:0]` holds the result, `rsp_dest[127:64]` is zero, and `rsp_write`=1.
- R9: With `half_sel`=1 on a legal encoding, `rsp_dest[127:64]` holds the result, `rsp_dest[63:0]` equals `dst_in[63:0]`, and `rsp_write`=1.
- R10: `rsp_write`, `rsp_undef` and `rsp_other` are never high together in pairs, and when `rsp_valid`=1 exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| imm_hi | input | 4 | Upper immediate field |
| imm_lo | input | 3 | Lower immediate field |
| half_sel | input | 1 | 0: write low half, clear high; 1: write high half, keep low |
| src | input | 128 | Wide source vector |
| dst_in | input | 128 | Current destination value |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_write | output | 1 | Legal encoding, destination updated |
| rsp_undef | output | 1 | Undefined encoding |
| rsp_other | output | 1 | Encoding of another class |
| rsp_dest | output | 128 | Resulting destination value |
| dbg_size | output | 2 | Narrow lane size code |
| dbg_shift | output | 6 | Decoded shift amount |

## Verification
The bench walks through every legal immediate for each lane width, so it hits both ends of the shift range: a shift of 1, and a shift of the full narrow width, where only the upper half of each lane survives. A decoder that takes the width from the lowest set bit instead of the highest, or that reads the shift off by one, makes the results disagree on exactly these sweeps. A result that lands in the wrong half, that leaves the high half uncleared, or that alters the preserved low half is caught by running both half-select settings on random destination data. Encodings of the other class and undefined encodings are sent with a nonzero destination, and the check confirms that the destination passes through unchanged and that the write flag is low.

// File: rtl/vnarrow_pkg.sv
package vnarrow_pkg;
  localparam int VEC_W   = 128;
  localparam int RES_W   = 64;
  localparam int SHIFT_W = 6;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_S = 2'd2
  } lane_size_e;

  typedef enum logic [1:0] {
    CLS_LEGAL = 2'd0,
    CLS_OTHER = 2'd1,
    CLS_UNDEF = 2'd2
  } enc_class_e;

  typedef struct packed {
    enc_class_e         cls;
    lane_size_e         size;
    logic [SHIFT_W-1:0] shift;
  } decode_t;
endpackage

// File: rtl/vnarrow_decode.sv
module vnarrow_decode
  import vnarrow_pkg::*;
(
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  output decode_t    dec
);
  logic [6:0] imm_full;
  logic [6:0] twice_w;
  logic [6:0] shift_full;

  assign imm_full = {imm_hi, imm_lo};

  always_comb begin
    dec = '0;
    twice_w = 7'd16;
    if (imm_hi == 4'b0000) begin
      dec.cls = CLS_OTHER;
    end else if (imm_hi[3]) begin
      dec.cls = CLS_UNDEF;
    end else begin
      dec.cls = CLS_LEGAL;
      if (imm_hi[2]) begin
        dec.size = SZ_S;
        twice_w  = 7'd64;
      end else if (imm_hi[1]) begin
        dec.size = SZ_H;
        twice_w  = 7'd32;
      end else begin
        dec.size = SZ_B;
        twice_w  = 7'd16;
      end
    end
    shift_full = twice_w - imm_full;
    if (dec.cls == CLS_LEGAL) dec.shift = shift_full[SHIFT_W-1:0];
  end

  always_comb begin
    if (dec.cls == CLS_LEGAL) begin
      AST_SHIFT_RANGE: assert (dec.shift >= 6'd1 &&
                               dec.shift <= (6'd8 << dec.size)); // R6
    end
  end
endmodule

// File: rtl/vnarrow_lanes.sv
module vnarrow_lanes
  import vnarrow_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int SRC_W    = 128
) (
  input  logic [SRC_W-1:0]   src,
  input  logic [SHIFT_W-1:0] shift,
  output logic [SRC_W/2-1:0] packed_o
);
  localparam int WIDE_W = 2 * NARROW_W;
  localparam int LANES  = SRC_W / WIDE_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] shifted;
    assign wide    = src[e*WIDE_W +: WIDE_W];
    assign shifted = wide >> shift;
    assign packed_o[e*NARROW_W +: NARROW_W] = shifted[NARROW_W-1:0];
  end
endmodule

// File: rtl/vnarrow_shr.sv
module vnarrow_shr
  import vnarrow_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [3:0]   imm_hi,
  input  logic [2:0]   imm_lo,
  input  logic         half_sel,
  input  logic [127:0] src,
  input  logic [127:0] dst_in,
  output logic         rsp_valid,
  output logic         rsp_write,
  output logic         rsp_undef,
  output logic         rsp_other,
  output logic [127:0] rsp_dest,
  output logic [1:0]   dbg_size,
  output logic [5:0]   dbg_shift
);
  localparam int NSIZES = 3;

  decode_t          dec;
  logic [RES_W-1:0] res_by_size [NSIZES];
  logic [RES_W-1:0] result;
  logic [VEC_W-1:0] dest_nxt;

  logic             valid_q, write_q, undef_q, other_q;
  logic [VEC_W-1:0] dest_q;
  logic [1:0]       size_q;
  logic [5:0]       shift_q;

  vnarrow_decode u_dec (
    .imm_hi (imm_hi),
    .imm_lo (imm_lo),
    .dec    (dec)
  );

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    vnarrow_lanes #(
      .NARROW_W (8 << s),
      .SRC_W    (VEC_W)
    ) u_lanes (
      .src      (src),
      .shift    (dec.shift),
      .packed_o (res_by_size[s])
    );
  end

  always_comb begin
    case (dec.size)
      SZ_H:    result = res_by_size[1];
      SZ_S:    result = res_by_size[2];
      default: result = res_by_size[0];
    endcase
    if (dec.cls != CLS_LEGAL) dest_nxt = dst_in;
    else if (half_sel)         dest_nxt = {result, dst_in[RES_W-1:0]};
    else                       dest_nxt = {{(VEC_W-RES_W){1'b0}}, result};
  end

  // control flops: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      undef_q <= 1'b0;
      other_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      write_q <= req_valid && (dec.cls == CLS_LEGAL);
      undef_q <= req_valid && (dec.cls == CLS_UNDEF);
      other_q <= req_valid && (dec.cls == CLS_OTHER);
    end
  end

  // data flops: enable only, no reset
  always_ff @(posedge clk) begin
    if (req_valid) begin
      dest_q  <= dest_nxt;
      size_q  <= dec.size;
      shift_q <= dec.shift;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_write = write_q;
  assign rsp_undef = undef_q;
  assign rsp_other = other_q;
  assign rsp_dest  = dest_q;
  assign dbg_size  = size_q;
  assign dbg_shift = shift_q;

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_write, rsp_undef, rsp_other})); // R10
  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_write, rsp_undef, rsp_other} == 3'b000)); // R10
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && imm_hi == 4'b0000) |=> (rsp_other && rsp_dest == $past(dst_in))); // R3
  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && imm_hi[3]) |=> (rsp_undef && rsp_dest == $past(dst_in))); // R4
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !half_sel && imm_hi != 4'b0000 && !imm_hi[3])
      |=> (rsp_dest[127:64] == '0)); // R8
  AST_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && half_sel && imm_hi != 4'b0000 && !imm_hi[3])
      |=> (rsp_dest[63:0] == $past(dst_in[63:0]))); // R9
endmodule

// File: tb/vnarrow_shr_test.sv
module vnarrow_shr_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [3:0]   imm_hi;
  logic [2:0]   imm_lo;
  logic         half_sel;
  logic [127:0] src, dst_in;
  logic         rsp_valid, rsp_write, rsp_undef, rsp_other;
  logic [127:0] rsp_dest;
  logic [1:0]   dbg_size;
  logic [5:0]   dbg_shift;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk; // 125 MHz

  vnarrow_shr uut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [63:0] model(input logic [127:0] s, input int w, input int sh);
    logic [63:0] r = '0;
    for (int e = 0; e < 64 / w; e++) begin
      logic [63:0] wide = '0;
      for (int b = 0; b < 2 * w; b++) wide[b] = s[e*2*w + b];
      wide = wide >> sh;
      for (int b = 0; b < w; b++) r[e*w + b] = wide[b];
    end
    return r;
  endfunction

  // drive at negedge, sample after next posedge
  task automatic issue(input logic [3:0] hi, input logic [2:0] lo, input logic hs,
                       input logic [127:0] s, input logic [127:0] d);
    @(negedge clk);
    req_valid = 1'b1; imm_hi = hi; imm_lo = lo; half_sel = hs; src = s; dst_in = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", {127'b0, rsp_valid}, 128'd0);
    chk("R1 flags", {125'b0, rsp_write, rsp_undef, rsp_other}, 128'd0);
  endtask

  task automatic t_sweep(input int sz);
    int w = 8 << sz;
    for (int v = 2 * w - w; v <= 2 * w - 1; v++) begin
      logic [6:0] imm = 7'(v);
      logic [127:0] s = rnd128();
      logic [127:0] d = rnd128();
      logic hs = v[0];
      logic [63:0] exp_r = model(s, w, 2 * w - v);
      issue(imm[6:3], imm[2:0], hs, s, d);
      chk("R2 valid", {127'b0, rsp_valid}, 128'd1);
      chk("R5 size", {126'b0, dbg_size}, 128'(sz));
      chk("R6 shift", {122'b0, dbg_shift}, 128'(2 * w - v));
      chk("R10 write", {125'b0, rsp_write, rsp_undef, rsp_other}, 128'd4);
      if (hs) chk("R9 R7 high", rsp_dest, {exp_r, d[63:0]});
      else    chk("R8 R7 low", rsp_dest, {64'd0, exp_r});
    end
  endtask

  task automatic t_halves();
    logic [127:0] s = {128{1'b1}};
    logic [127:0] d = rnd128();
    // shift of full width (imm = 8 for bytes): each lane keeps its upper byte
    issue(4'b0001, 3'b000, 1'b0, s, d);
    chk("R8 full shift", rsp_dest, {64'd0, {64{1'b1}}});
    issue(4'b0001, 3'b111, 1'b1, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, d);
    chk("R9 shift1", rsp_dest, {model(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 8, 1), d[63:0]});
  endtask

  task automatic t_other();
    logic [127:0] d = rnd128();
    issue(4'b0000, 3'b101, 1'b1, rnd128(), d);
    chk("R3 flags", {125'b0, rsp_write, rsp_undef, rsp_other}, 128'd1);
    chk("R3 dest", rsp_dest, d);
  endtask

  task automatic t_undef();
    logic [127:0] d = rnd128();
    issue(4'b1010, 3'b011, 1'b0, rnd128(), d);
    chk("R4 flags", {125'b0, rsp_write, rsp_undef, rsp_other}, 128'd2);
    chk("R4 dest", rsp_dest, d);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R2 idle", {124'b0, rsp_valid, rsp_write, rsp_undef, rsp_other}, 128'd0);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; req_valid = 1'b0; imm_hi = '0; imm_lo = '0;
        half_sel = 1'b0; src = '0; dst_in = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        for (int sz = 0; sz < 3; sz++) t_sweep(sz);
        t_halves();
        t_other();
        t_undef();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule